// File: doc/BRIEF.md
# Serial Link Power-Up Sequencer

This block is the transmitting-side controller that takes a three-wire serial display link (one clock line, a parameterised number of data lines) from the powered-off condition to a running, idle link. An active-low power-down input holds every line at zero current and keeps the sequencing logic cleared. Once power-down is released the block waits a fixed number of reference-clock periods, standing in for the settling time of the clock multiplier. It then plays a three-step calibration pattern on the lines so the receiving end can tune its input thresholds, and finally starts toggling the link clock.

The block runs on the link clock, which is a fixed multiple of the reference clock, so the lock wait is counted in link-clock cycles. Per-line drive levels are presented as two-bit codes for the analog drivers, and a ready flag tells the write serializer when transfers may begin. Writes offered before the link is ready are refused and flagged. A power-down request made while the link is running is only honoured after the link has stayed quiet long enough for the far end to finish any writes in flight.

Top module: `link_powerup_seq`

## Requirements
- R1: Line drive codes are 2'b00 for zero current, 2'b01 for logic low and 2'b10 for logic high; data lane i occupies `md_drv[2i+1:2i]`. While `rst_n` is low, and in the cycle after any clock edge that samples `pd_n` low outside the running and draining states, every line reads 2'b00 and `link_ready` is low.
- R2: After the clock edge that first samples `pd_n` high in the off state, all lines stay at 2'b00 for exactly LOCK_REF_CYCLES x CLK_MULT link-clock cycles (16384 with defaults).
- R3: Calibration step one follows: clock line low, all data lines high, for CAL_CYCLES cycles (180).
- R4: Calibration step two follows step one: clock line high, all data lines high, for CAL_CYCLES cycles.
- R5: Calibration step three follows step two: clock line and all data lines low, for CAL_CYCLES cycles.
- R6: In the cycle after step three `link_ready` rises; from then the clock line alternates high and low every cycle, starting high, and the data lines rest high. The total from the end of the lock wait to ready is 3 x CAL_CYCLES cycles (540).
- R7: `link_ready` is low before that point; a `wr_req` while `link_ready` is low gets `wr_accept` low in the same cycle and `wr_err` high in the next cycle.
- R8: A `wr_req` while `link_ready` is high gets `wr_accept` high in the same cycle and no `wr_err` in the next.
- R9: When `pd_n` is sampled low while running, the link turns off only after IDLE_MIN (20) consecutive cycles with `link_busy` low; until then the clock keeps toggling, data lines stay high and `link_ready` is low. If the quiet streak is already complete, the lines read 2'b00 in the next cycle.
- R10: If `pd_n` returns high while a power-down is waiting for the quiet streak, `link_ready` is high again in the next cycle with no new lock wait or calibration.
- R11: Sampling `pd_n` low during the lock wait or calibration turns the lines off in the next cycle, and a later release repeats the whole lock wait and calibration from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock (CLK_MULT x reference clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low |
| link_busy | input | 1 | High while the serializer has a transfer in flight |
| wr_req | input | 1 | Host write request |
| wr_accept | output | 1 | Write accepted this cycle |
| wr_err | output | 1 | One-cycle flag: previous write was refused |
| link_ready | output | 1 | Link running and open for writes |
| mc_drv | output | 2 | Clock line drive code |
| md_drv | output | 2*NUM_DATA | Data line drive codes, two bits per lane |

## Verification
On every cycle the assertions check that power-down outside the running states forces all lines off, that the three calibration steps are only ever entered in their fixed order, that the clock alternates while running, that refused and accepted writes produce the right error flag, and that no running link turns off before an independently counted quiet streak. The exact lengths of the lock wait and of each calibration step, the total time to ready, the deferred shutdown boundary at the twentieth quiet cycle, the cancel of a pending power-down and the restart after an aborted calibration are shown only by the bench's scenarios, which measure run lengths of the line codes against a queue of expected steps.

// File: rtl/lps_pkg.sv
// Shared types for the link power-up sequencer.
// Assumes: line codes are consumed by analog drivers outside this block.
package lps_pkg;

    // Sequencer phases, in the order the link normally walks them.
    typedef enum logic [2:0] {
        S_OFF      = 3'd0,
        S_LOCK     = 3'd1,
        S_CAL_LO   = 3'd2,
        S_CAL_HI   = 3'd3,
        S_CAL_BOTH = 3'd4,
        S_READY    = 3'd5,
        S_DRAIN    = 3'd6
    } lps_state_t;

    // Drive level of one link line.
    typedef enum logic [1:0] {
        LINE_OFF  = 2'b00,
        LINE_LOW  = 2'b01,
        LINE_HIGH = 2'b10
    } line_lvl_t;

endpackage

// File: rtl/lps_cycle_timer.sv
// Counts cycles while a phase runs and flags its last cycle.
// Assumes: restart is high on every cycle in which the owning phase changes,
// so each phase starts counting from zero.
module lps_cycle_timer #(
    parameter int LIMIT = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Phase cycle counter, cleared on reset and on any phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Last cycle of the phase.
    always_comb begin
        done = run && (cnt == LAST);
    end
endmodule

// File: rtl/lps_idle_tracker.sv
// Measures how long the link has been quiet while running or draining.
// Assumes: link_busy comes from the serializer on the same clock.
module lps_idle_tracker #(
    parameter int IDLE_MIN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic link_busy,
    output logic idle_ok
);
    localparam int IW = $clog2(IDLE_MIN + 1);
    localparam logic [IW-1:0] SAT = IW'(IDLE_MIN);

    logic [IW-1:0] streak;

    // Saturating count of consecutive quiet cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || link_busy) begin
            streak <= '0;
        end else if (streak != SAT) begin
            streak <= streak + 1'b1;
        end
    end

    // Quiet long enough for the far end to finish pending writes.
    always_comb begin
        idle_ok = (streak == SAT);
    end
endmodule

// File: rtl/lps_line_drive.sv
// Maps the sequencer phase to clock-line and data-line drive codes.
// Assumes: the running clock starts high in the first running cycle.
module lps_line_drive
    import lps_pkg::*;
#(
    parameter int NUM_DATA = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  lps_state_t            st,
    output logic [1:0]            mc_drv,
    output logic [2*NUM_DATA-1:0] md_drv
);
    logic       running;
    logic       phase_tgl;
    line_lvl_t  clk_lvl;
    line_lvl_t  dat_lvl;

    // Link clock runs in both the ready and draining phases.
    always_comb begin
        running = (st == S_READY) || (st == S_DRAIN);
    end

    // Toggle flop for the running link clock, parked while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            phase_tgl <= 1'b0;
        end else begin
            phase_tgl <= ~phase_tgl;
        end
    end

    // Phase to line level decode.
    always_comb begin
        clk_lvl = LINE_OFF;
        dat_lvl = LINE_OFF;
        case (st)
            S_CAL_LO: begin
                clk_lvl = LINE_LOW;
                dat_lvl = LINE_HIGH;
            end
            S_CAL_HI: begin
                clk_lvl = LINE_HIGH;
                dat_lvl = LINE_HIGH;
            end
            S_CAL_BOTH: begin
                clk_lvl = LINE_LOW;
                dat_lvl = LINE_LOW;
            end
            S_READY, S_DRAIN: begin
                clk_lvl = phase_tgl ? LINE_LOW : LINE_HIGH;
                dat_lvl = LINE_HIGH;
            end
            default: begin
                clk_lvl = LINE_OFF;
                dat_lvl = LINE_OFF;
            end
        endcase
    end

    assign mc_drv = clk_lvl;

    // Every data lane carries the same level during bring-up.
    for (genvar g = 0; g < NUM_DATA; g++) begin : g_lane
        assign md_drv[2*g +: 2] = dat_lvl;
    end
endmodule

// File: rtl/lps_write_gate.sv
// Lets host writes through only while the link is ready; flags the rest.
// Assumes: a refused write is simply dropped, the host retries on its own.
module lps_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic wr_req,
    output logic wr_accept,
    output logic wr_err
);
    // Same-cycle acceptance.
    always_comb begin
        wr_accept = wr_req && ready;
    end

    // One-cycle error pulse for a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_req && !ready;
        end
    end
endmodule

// File: rtl/link_powerup_seq.sv
// Top of the serial link power-up sequencer.
// Walks off -> lock wait -> three calibration steps -> running, and back to
// off on power-down, deferring shutdown of a running link until it is quiet.
// Assumes: clk is the link clock, CLK_MULT times the reference clock.
module link_powerup_seq
    import lps_pkg::*;
#(
    parameter int NUM_DATA        = 2,
    parameter int LOCK_REF_CYCLES = 4096,
    parameter int CLK_MULT        = 4,
    parameter int CAL_CYCLES      = 180,
    parameter int IDLE_MIN        = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_n,
    input  logic                  link_busy,
    input  logic                  wr_req,
    output logic                  wr_accept,
    output logic                  wr_err,
    output logic                  link_ready,
    output logic [1:0]            mc_drv,
    output logic [2*NUM_DATA-1:0] md_drv
);
    localparam int LOCK_CYCLES = LOCK_REF_CYCLES * CLK_MULT;

    lps_state_t state;
    lps_state_t state_nxt;
    logic       restart;
    logic       lock_done;
    logic       cal_done;
    logic       in_cal;
    logic       running;
    logic       idle_ok;

    // Phase classification used by the timers and the tracker.
    always_comb begin
        in_cal  = (state == S_CAL_LO) || (state == S_CAL_HI) || (state == S_CAL_BOTH);
        running = (state == S_READY) || (state == S_DRAIN);
    end

    // Next-phase decision.
    always_comb begin
        state_nxt = state;
        case (state)
            S_OFF:      if (pd_n) state_nxt = S_LOCK;
            S_LOCK:     if (!pd_n) state_nxt = S_OFF;
                        else if (lock_done) state_nxt = S_CAL_LO;
            S_CAL_LO:   if (!pd_n) state_nxt = S_OFF;
                        else if (cal_done) state_nxt = S_CAL_HI;
            S_CAL_HI:   if (!pd_n) state_nxt = S_OFF;
                        else if (cal_done) state_nxt = S_CAL_BOTH;
            S_CAL_BOTH: if (!pd_n) state_nxt = S_OFF;
                        else if (cal_done) state_nxt = S_READY;
            S_READY:    if (!pd_n) state_nxt = idle_ok ? S_OFF : S_DRAIN;
            S_DRAIN:    if (pd_n) state_nxt = S_READY;
                        else if (idle_ok) state_nxt = S_OFF;
            default:    state_nxt = S_OFF;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Timers restart whenever the phase is about to change.
    always_comb begin
        restart = (state_nxt != state);
    end

    lps_cycle_timer #(.LIMIT(LOCK_CYCLES)) i_lock_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (state == S_LOCK),
        .done    (lock_done)
    );

    lps_cycle_timer #(.LIMIT(CAL_CYCLES)) i_cal_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (in_cal),
        .done    (cal_done)
    );

    lps_idle_tracker #(.IDLE_MIN(IDLE_MIN)) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (running),
        .link_busy (link_busy),
        .idle_ok   (idle_ok)
    );

    lps_line_drive #(.NUM_DATA(NUM_DATA)) i_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .st     (state),
        .mc_drv (mc_drv),
        .md_drv (md_drv)
    );

    // Writes are open only in the ready phase, not while draining.
    always_comb begin
        link_ready = (state == S_READY);
    end

    lps_write_gate i_wgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (link_ready),
        .wr_req    (wr_req),
        .wr_accept (wr_accept),
        .wr_err    (wr_err)
    );
endmodule

// File: rtl/lps_checker.sv
// Property checker for link_powerup_seq, attached by bind below.
// Keeps its own quiet-cycle count so shutdown timing is judged independently.
module lps_checker
    import lps_pkg::*;
#(
    parameter int NUM_DATA = 2,
    parameter int IDLE_MIN = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pd_n,
    input logic                  link_busy,
    input logic                  wr_req,
    input logic                  wr_accept,
    input logic                  wr_err,
    input logic                  link_ready,
    input logic [1:0]            mc_drv,
    input logic [2*NUM_DATA-1:0] md_drv,
    input lps_state_t            st
);
    localparam int QW = $clog2(IDLE_MIN + 1);

    logic [QW-1:0] quiet;

    // Independent saturating count of cycles with link_busy low.
    always_ff @(posedge clk) begin
        if (!rst_n || link_busy) begin
            quiet <= '0;
        end else if (quiet != QW'(IDLE_MIN)) begin
            quiet <= quiet + 1'b1;
        end
    end

    AST_OFF_ON_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_n && st != S_READY && st != S_DRAIN) |=> (mc_drv == 2'b00 && md_drv == '0)); // R1

    AST_STEP2_AFTER_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CAL_HI && $past(st) != S_CAL_HI) |-> ($past(st) == S_CAL_LO)); // R4

    AST_STEP3_AFTER_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CAL_BOTH && $past(st) != S_CAL_BOTH) |-> ($past(st) == S_CAL_HI)); // R5

    AST_READY_AFTER_STEP3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_ready) && $past(st) != S_DRAIN) |-> ($past(mc_drv) == 2'b01)); // R6

    AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ready && $past(link_ready)) |-> (mc_drv != $past(mc_drv))); // R6

    AST_EARLY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !link_ready) |=> wr_err); // R7

    AST_EARLY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !link_ready) |-> !wr_accept); // R7

    AST_READY_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && link_ready) |=> !wr_err); // R8

    AST_SHUTDOWN_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OFF && ($past(st) == S_READY || $past(st) == S_DRAIN))
            |-> ($past(quiet) == QW'(IDLE_MIN))); // R9
endmodule

bind link_powerup_seq lps_checker #(
    .NUM_DATA (NUM_DATA),
    .IDLE_MIN (IDLE_MIN)
) i_lps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .link_busy  (link_busy),
    .wr_req     (wr_req),
    .wr_accept  (wr_accept),
    .wr_err     (wr_err),
    .link_ready (link_ready),
    .mc_drv     (mc_drv),
    .md_drv     (md_drv),
    .st         (state)
);

// File: tb/test_link_powerup_seq.sv
module test_link_powerup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_DATA   = 2;
    localparam int LOCK_EXP   = 4096 * 4;
    localparam int CAL_EXP    = 180;
    localparam int IDLE_EXP   = 20;
    localparam logic [3:0] MD_HI = 4'b1010;
    localparam logic [3:0] MD_LO = 4'b0101;

    logic clk = 1'b0;
    logic rst_n, pd_n, link_busy, wr_req;
    logic wr_accept, wr_err, link_ready;
    logic [1:0] mc_drv;
    logic [2*NUM_DATA-1:0] md_drv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // Scoreboard of expected calibration steps.
    logic [5:0] q_val[$];
    int         q_len[$];
    string      q_req[$];
    bit         mon_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_powerup_seq i_link_powerup_seq (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .link_busy(link_busy),
        .wr_req(wr_req), .wr_accept(wr_accept), .wr_err(wr_err),
        .link_ready(link_ready), .mc_drv(mc_drv), .md_drv(md_drv)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compress line codes into runs and compare finished runs.
    logic [5:0] run_val;
    int         run_len = 0;
    always @(negedge clk) begin
        logic [5:0] cur;
        cur = {mc_drv, md_drv};
        if (!mon_en) begin
            run_len = 0;
        end else begin
            if (run_len > 0 && (cur != run_val || link_ready)) begin
                if (run_val != 6'd0) begin
                    if (q_val.size() == 0) begin
                        check(0, "R3", "unexpected step", int'(run_val), 0);
                    end else begin
                        logic [5:0] ev;
                        int el;
                        string er;
                        ev = q_val.pop_front();
                        el = q_len.pop_front();
                        er = q_req.pop_front();
                        check(run_val == ev, er, "step line codes", int'(run_val), int'(ev));
                        check(run_len == el, er, "step length", run_len, el);
                    end
                end
                run_len = 0;
            end
            if (!link_ready) begin
                if (run_len == 0) run_val = cur;
                run_len++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Full power-up with all step checks (R2..R7).
    task automatic power_up();
        int n;
        int c;
        q_val.push_back({2'b01, MD_HI}); q_len.push_back(CAL_EXP); q_req.push_back("R3");
        q_val.push_back({2'b10, MD_HI}); q_len.push_back(CAL_EXP); q_req.push_back("R4");
        q_val.push_back({2'b01, MD_LO}); q_len.push_back(CAL_EXP); q_req.push_back("R5");
        mon_en = 1;
        @(negedge clk);
        pd_n = 1'b1;
        n = 0;
        @(negedge clk);
        while (mc_drv == 2'b00 && md_drv == '0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
        check(n == LOCK_EXP, "R2", "lock wait cycles", n, LOCK_EXP);
        c = 1;
        repeat (10) begin @(negedge clk); c++; end
        wr_req = 1'b1;
        #1;
        check(wr_accept == 1'b0, "R7", "early write accept", wr_accept, 0);
        @(negedge clk); c++;
        wr_req = 1'b0;
        check(wr_err == 1'b1, "R7", "early write error", wr_err, 1);
        check(link_ready == 1'b0, "R7", "ready during calibration", link_ready, 0);
        while (!link_ready && c < 2000) begin @(negedge clk); c++; end
        check(c == 3*CAL_EXP + 1, "R6", "cycles to ready", c, 3*CAL_EXP + 1);
        check(mc_drv == 2'b10, "R6", "first running clock", mc_drv, 2);
        check(md_drv == MD_HI, "R6", "running data idle", md_drv, MD_HI);
        for (int i = 0; i < 4; i++) begin
            logic [1:0] prev;
            prev = mc_drv;
            @(negedge clk);
            check(mc_drv != prev && mc_drv != 2'b00, "R6", "clock toggle", mc_drv, 3 - prev);
        end
        mon_en = 0;
        check(q_val.size() == 0, "R5", "steps left unseen", q_val.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; pd_n = 1'b0; link_busy = 1'b0; wr_req = 1'b0;
        repeat (5) @(negedge clk);
        check(mc_drv == 2'b00 && md_drv == '0, "R1", "lines in reset", {mc_drv, md_drv}, 0);
        check(link_ready == 1'b0, "R1", "ready in reset", link_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mc_drv == 2'b00 && md_drv == '0, "R1", "lines while powered down", {mc_drv, md_drv}, 0);

        power_up();

        // R8: write while ready.
        wr_req = 1'b1;
        #1;
        check(wr_accept == 1'b1, "R8", "ready write accept", wr_accept, 1);
        @(negedge clk);
        wr_req = 1'b0;
        check(wr_err == 1'b0, "R8", "ready write error", wr_err, 0);

        // R9: deferred shutdown while busy.
        link_busy = 1'b1;
        pd_n = 1'b0;
        @(negedge clk);
        check(link_ready == 1'b0, "R9", "ready while draining", link_ready, 0);
        check(mc_drv != 2'b00 && md_drv == MD_HI, "R9", "lines while draining", {mc_drv, md_drv}, 1);
        repeat (30) @(negedge clk);
        check(mc_drv != 2'b00, "R9", "still on while busy", mc_drv, 1);
        link_busy = 1'b0;
        repeat (20) @(negedge clk);
        check(mc_drv != 2'b00, "R9", "on at quiet cycle 20", mc_drv, 1);
        @(negedge clk);
        check(mc_drv == 2'b00 && md_drv == '0, "R9", "off after quiet streak", {mc_drv, md_drv}, 0);

        // R10: cancel a pending power-down.
        power_up();
        link_busy = 1'b1;
        pd_n = 1'b0;
        repeat (5) @(negedge clk);
        check(link_ready == 1'b0 && mc_drv != 2'b00, "R9", "drain holds link", link_ready, 0);
        pd_n = 1'b1;
        link_busy = 1'b0;
        @(negedge clk);
        check(link_ready == 1'b1, "R10", "ready after cancel", link_ready, 1);
        check(md_drv == MD_HI, "R10", "data idle after cancel", md_drv, MD_HI);

        // R9: already quiet, shutdown next cycle.
        repeat (25) @(negedge clk);
        pd_n = 1'b0;
        @(negedge clk);
        check(mc_drv == 2'b00 && md_drv == '0 && !link_ready, "R9", "immediate off when quiet",
              {mc_drv, md_drv}, 0);

        // R11: abort during calibration step two, then full restart.
        @(negedge clk);
        pd_n = 1'b1;
        begin
            int n;
            n = 0;
            while (mc_drv == 2'b00 && n < 20000) begin @(negedge clk); n++; end
        end
        repeat (200) @(negedge clk);
        check(mc_drv == 2'b10, "R11", "in step two before abort", mc_drv, 2);
        pd_n = 1'b0;
        @(negedge clk);
        check(mc_drv == 2'b00 && md_drv == '0, "R11", "off after abort", {mc_drv, md_drv}, 0);
        repeat (3) @(negedge clk);
        power_up();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule